// File: doc/BRIEF.md
# Complementary Dead-Time Gate Sequencer

This block takes a single pulse-width-modulated phase level and produces a complementary pair of gate-drive enables for one half-bridge leg. The high-side enable follows the phase level and the low-side enable follows its inverse. Every hand-over between the two passes through an interval in which both are low. The length of that interval is the larger of a built-in floor and a programmed count, so a zero setting can never shorten it below a safe value.

Three safety conditions override the sequencing. An active-low shutdown level forces both enables low. A lockout on the logic supply also forces both low. A lockout on the floating high-side supply removes only the high-side enable. Each supply lockout is hysteretic: it engages on a "below falling threshold" flag, releases on an "above rising threshold" flag, and holds its state when neither flag is set. After any release, and after reset, no enable rises until a full dead-time interval has run. The phase and shutdown levels pass through a two-flop synchroniser. The supply flags arrive already digitised and clocked.

At 125 MHz the default floor of 46 cycles is about 370 ns. The largest 8-bit setting of 255 cycles is about 2.0 us.

Top module: `comp_deadtime_seq`

## Requirements
- R1: Once a hand-over has completed, `hs_en_o` equals the synchronised phase level and `ls_en_o` equals its inverse, and both hold while the phase level is steady.
- R2: `hs_en_o` and `ls_en_o` are never high together. Counting the clock edge that first samples a new `pwm_i` level as edge 0, the enable that was high goes low at edge 2.
- R3: After the R2 turn-off, both enables stay low for exactly L = max(MIN_DT, `dt_set_i`) clock cycles, and the newly selected enable rises at edge 2+L.
- R4: A `dt_set_i` value below MIN_DT, including 0, gives L = MIN_DT.
- R5: A `dt_set_i` value at or above MIN_DT gives L = `dt_set_i`, up to the largest value of 2^CNT_W-1.
- R6: If the phase level changes again before the interval expires, the interval restarts from the later change. A phase pulse shorter than L never turns on the other enable.
- R7: `shdn_n_i` = 0 forces both enables low at edge 2 after it is sampled, whatever the phase level does. When `shdn_n_i` returns to 1, the selected enable rises at edge 1+L.
- R8: The logic-supply lockout engages when `lv_fall_bad_i` = 1 and releases only when `lv_rise_ok_i` = 1 with `lv_fall_bad_i` = 0. With both flags 0 it keeps its state. While it is engaged, both enables go low from edge 1.
- R9: The high-side supply lockout (`hv_fall_bad_i` / `hv_rise_ok_i`, with the same hysteresis) removes only `hs_en_o`, from edge 1. The low-side enable turns on, stays on and hands over as usual while it is engaged.
- R10: When a supply lockout releases (edge 0 samples the rise flag), the selected enable rises at edge L.
- R11: During and after reset, both enables are low and both lockouts are engaged. The shutdown synchroniser resets to the shutdown state, so no enable rises until the supplies are released and a full interval has elapsed.
- R12: `fault_o` is 1 while the synchronised shutdown or either lockout is active, and follows those states one edge later. It is 1 at reset, rises or falls at edge 2 for shutdown, and at edge 1 for a lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Phase level, 1 selects the high side |
| shdn_n_i | input | 1 | Shutdown, active low, asynchronous to clk |
| dt_set_i | input | CNT_W | Requested dead time in clock cycles |
| lv_rise_ok_i | input | 1 | Logic supply above its rising threshold |
| lv_fall_bad_i | input | 1 | Logic supply below its falling threshold |
| hv_rise_ok_i | input | 1 | Floating supply above its rising threshold |
| hv_fall_bad_i | input | 1 | Floating supply below its falling threshold |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Shutdown or lockout holding the outputs |

## Verification
The bench builds the block with CNT_W = 6 and MIN_DT = 6. These values let settings 0 to 5 exercise the floor, 6 and 7 sit just on and above it, and the largest setting of 63 finish in a few dozen cycles. With dead times this short, every edge count in R2, R3, R7, R9 and R10 can be measured directly, cycle by cycle. The restart of R6 can also be exercised with a two-cycle phase glitch that is shorter than the interval.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    typedef enum logic [1:0] {
        SEQ_ARM   = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_DRIVE = 2'd2
    } seq_mode_e;

    localparam int SUP_LOGIC = 0;
    localparam int SUP_FLOAT = 1;
    localparam int SUP_COUNT = 2;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/supply_lock_latch.sv
module supply_lock_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ok_i,
    input  logic fall_bad_i,
    output logic locked_o
);

    logic lock_d, lock_q;

    // falling flag dominates; neither flag keeps the state (hysteresis band)
    always_comb begin
        lock_d = lock_q;
        if (fall_bad_i) begin
            lock_d = 1'b1;
        end else if (rise_ok_i) begin
            lock_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign locked_o = lock_q;

endmodule

// File: rtl/dt_len_sel.sv
module dt_len_sel #(
    parameter int CNT_W  = 8,
    parameter int MIN_DT = 46
) (
    input  logic [CNT_W-1:0] dt_set_i,
    output logic [CNT_W-1:0] len_m1_o
);

    localparam logic [CNT_W-1:0] FLOOR   = CNT_W'(MIN_DT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] len;

    always_comb begin
        len      = (dt_set_i < FLOOR) ? FLOOR : dt_set_i;
        len_m1_o = len - CNT_ONE;
    end

endmodule

// File: rtl/comp_deadtime_seq.sv
module comp_deadtime_seq
    import cgs_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int MIN_DT      = 46,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_i,
    input  logic             shdn_n_i,
    input  logic [CNT_W-1:0] dt_set_i,
    input  logic             lv_rise_ok_i,
    input  logic             lv_fall_bad_i,
    input  logic             hv_rise_ok_i,
    input  logic             hv_fall_bad_i,
    output logic             hs_en_o,
    output logic             ls_en_o,
    output logic             fault_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        seq_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic             sel;
        logic             hs;
        logic             ls;
        logic             fault;
    } seq_reg_t;

    localparam seq_reg_t SEQ_RST = '{
        mode:  SEQ_ARM,
        cnt:   '0,
        sel:   1'b0,
        hs:    1'b0,
        ls:    1'b0,
        fault: 1'b1
    };

    // ---------------- synchronised phase and shutdown ----------------
    logic [1:0] sync_q;
    logic       pwm_s;
    logic       sd_act;

    level_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({shdn_n_i, pwm_i}),
        .q_o   (sync_q)
    );

    assign pwm_s  = sync_q[0];
    assign sd_act = ~sync_q[1];

    // ---------------- per-supply hysteretic lockouts ----------------
    logic [SUP_COUNT-1:0] rise_v, fall_v, lock_v;
    logic                 lv_lock, hv_lock;

    always_comb begin
        rise_v[SUP_LOGIC] = lv_rise_ok_i;
        fall_v[SUP_LOGIC] = lv_fall_bad_i;
        rise_v[SUP_FLOAT] = hv_rise_ok_i;
        fall_v[SUP_FLOAT] = hv_fall_bad_i;
    end

    for (genvar g = 0; g < SUP_COUNT; g++) begin : g_sup
        supply_lock_latch u_lock (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_ok_i  (rise_v[g]),
            .fall_bad_i (fall_v[g]),
            .locked_o   (lock_v[g])
        );
    end

    assign lv_lock = lock_v[SUP_LOGIC];
    assign hv_lock = lock_v[SUP_FLOAT];

    // ---------------- dead-time length ----------------
    logic [CNT_W-1:0] len_m1;

    dt_len_sel #(
        .CNT_W  (CNT_W),
        .MIN_DT (MIN_DT)
    ) u_len (
        .dt_set_i (dt_set_i),
        .len_m1_o (len_m1)
    );

    // ---------------- sequencer ----------------
    seq_reg_t r_d, r_q;
    logic     blk_all;
    logic     restart;

    always_comb begin
        r_d     = r_q;
        blk_all = sd_act | lv_lock;
        // any blocking condition, a new phase level, or the post-reset arm
        // state reloads a full interval with both enables low
        restart = (r_q.mode == SEQ_ARM) | blk_all
                | (pwm_s & hv_lock) | (pwm_s != r_q.sel);

        if (restart) begin
            r_d.mode = SEQ_WAIT;
            r_d.cnt  = len_m1;
            r_d.sel  = pwm_s;
            r_d.hs   = 1'b0;
            r_d.ls   = 1'b0;
        end else if (r_q.mode == SEQ_WAIT) begin
            if (r_q.cnt == '0) begin
                r_d.mode = SEQ_DRIVE;
                r_d.hs   = r_q.sel;
                r_d.ls   = ~r_q.sel;
            end else begin
                r_d.cnt = r_q.cnt - CNT_ONE;
            end
        end

        r_d.fault = blk_all | hv_lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_en_o = r_q.hs;
    assign ls_en_o = r_q.ls;
    assign fault_o = r_q.fault;

endmodule

// File: rtl/comp_deadtime_seq_chk.sv
module comp_deadtime_seq_chk #(
    parameter int MIN_DT = 46
) (
    input logic clk,
    input logic rst_n,
    input logic hs_en,
    input logic ls_en,
    input logic fault,
    input logic sd_act,
    input logic lv_lock,
    input logic hv_lock,
    input logic pwm_s,
    input logic lv_rise,
    input logic lv_fall
);

    localparam int RUN_W = $clog2(MIN_DT + 1) + 1;

    logic [RUN_W-1:0] off_run;

    // consecutive both-low cycles, saturating at the floor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
        end else if (hs_en || ls_en) begin
            off_run <= '0;
        end else if (off_run < RUN_W'(MIN_DT)) begin
            off_run <= off_run + RUN_W'(1);
        end
    end

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_phase_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> $past(pwm_s));

    p_phase_ls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en |-> !$past(pwm_s));

    p_min_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_en) || $rose(ls_en)) |-> (off_run >= RUN_W'(MIN_DT)));

    p_shdn_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_act |=> (!hs_en && !ls_en));

    p_lv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lv_lock |=> (!hs_en && !ls_en));

    p_lv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lv_rise && !lv_fall) |=> $stable(lv_lock));

    p_hv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hv_lock |=> !hs_en);

    p_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_act || lv_lock || hv_lock) |=> fault);

endmodule

bind comp_deadtime_seq comp_deadtime_seq_chk #(
    .MIN_DT (MIN_DT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_en   (hs_en_o),
    .ls_en   (ls_en_o),
    .fault   (fault_o),
    .sd_act  (sd_act),
    .lv_lock (lv_lock),
    .hv_lock (hv_lock),
    .pwm_s   (pwm_s),
    .lv_rise (lv_rise_ok_i),
    .lv_fall (lv_fall_bad_i)
);

// File: tb/test_comp_deadtime_seq.sv
module test_comp_deadtime_seq;

    localparam int CNT_W  = 6;
    localparam int MIN_DT = 6;

    logic             clk     = 1'b0;
    logic             rst_n   = 1'b0;
    logic             pwm     = 1'b0;
    logic             shdn_n  = 1'b1;
    logic [CNT_W-1:0] dt      = '0;
    logic             lv_rise = 1'b0;
    logic             lv_fall = 1'b1;
    logic             hv_rise = 1'b0;
    logic             hv_fall = 1'b1;
    logic             hs, ls, fault;

    int n_vec = 0;
    int n_bad = 0;

    comp_deadtime_seq #(
        .CNT_W  (CNT_W),
        .MIN_DT (MIN_DT)
    ) i_comp_deadtime_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_i         (pwm),
        .shdn_n_i      (shdn_n),
        .dt_set_i      (dt),
        .lv_rise_ok_i  (lv_rise),
        .lv_fall_bad_i (lv_fall),
        .hv_rise_ok_i  (hv_rise),
        .hv_fall_bad_i (hv_fall),
        .hs_en_o       (hs),
        .ls_en_o       (ls),
        .fault_o       (fault)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [5:0] dts;
        logic       lvl;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{6'd0,  1'b1}, '{6'd0,  1'b0}, '{6'd3,  1'b1}, '{6'd6,  1'b0},
        '{6'd7,  1'b1}, '{6'd20, 1'b0}, '{6'd63, 1'b1}, '{6'd1,  1'b0},
        '{6'd13, 1'b1}, '{6'd40, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int d);
        return (d < MIN_DT) ? MIN_DT : d;
    endfunction

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after a negedge with the opposite side driving.
    task automatic switch_to(input logic lvl, input int d, input string tag);
        int k;
        int off;
        dt  = CNT_W'(d);
        pwm = lvl;
        k   = 0;
        do begin
            @(negedge clk);
            k++;
        end while (((lvl ? ls : hs) == 1'b1) && k < 50);
        chk({tag, " R2 turn-off edge"}, k, 3);
        chk({tag, " R2 new side still low"}, int'(lvl ? hs : ls), 0);
        off = 1;
        @(negedge clk);
        while (!(lvl ? hs : ls) && off < 400) begin
            off++;
            @(negedge clk);
        end
        chk({tag, " R3 dead-time length"}, off, exp_len(d));
        chk({tag, " R1 phase pair"}, int'({hs, ls}), lvl ? 2 : 1);
        wait_neg(3);
        chk({tag, " R1 pair holds"}, int'({hs, ls}), lvl ? 2 : 1);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int  k;
        bit  ls_seen;

        // ---------------- reset (R11) ----------------
        wait_neg(5);
        chk("R11 hs low in reset", int'(hs), 0);
        chk("R11 ls low in reset", int'(ls), 0);
        chk("R12 fault high in reset", int'(fault), 1);
        rst_n = 1'b1;
        wait_neg(10);
        chk("R11 hs low, supplies locked", int'(hs), 0);
        chk("R11 ls low, supplies locked", int'(ls), 0);
        chk("R8 fault while locked", int'(fault), 1);

        // release both supplies: low side rises at edge L
        lv_fall = 1'b0; hv_fall = 1'b0; lv_rise = 1'b1; hv_rise = 1'b1;
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (k == 1) chk("R12 fault before release edge", int'(fault), 1);
            if (k == 2) chk("R12 fault cleared at edge 1", int'(fault), 0);
            if (ls) break;
        end
        chk("R10 first turn-on after release", k, MIN_DT + 1);
        chk("R11 hs stays low", int'(hs), 0);

        lv_rise = 1'b0; hv_rise = 1'b0;
        wait_neg(8);
        chk("R8 neither flag keeps unlocked", int'(ls), 1);
        chk("R8 fault stays low in band", int'(fault), 0);

        // ---------------- vector walk (R1..R5) ----------------
        for (int i = 0; i < 10; i++) begin
            switch_to(VECS[i].lvl, int'(VECS[i].dts),
                      (int'(VECS[i].dts) < MIN_DT) ? "R4 floor" : "R5 programmed");
        end

        // ---------------- R6 restart on a short glitch ----------------
        switch_to(1'b1, 10, "R6 setup");
        ls_seen = 1'b0;
        k   = 0;
        pwm = 1'b0;
        repeat (2) begin
            @(negedge clk);
            k++;
            ls_seen |= ls;
        end
        pwm = 1'b1;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (k == 3) chk("R6 hs dropped on glitch", int'(hs), 0);
            ls_seen |= ls;
            if (hs) break;
        end
        chk("R6 restart from second change", k, 15);
        chk("R6 low side never driven", int'(ls_seen), 0);

        // ---------------- R7 shutdown ----------------
        shdn_n = 1'b0;
        k = 0;
        while (k < 50) begin
            @(negedge clk);
            k++;
            if (!hs) break;
        end
        chk("R7 shutdown turn-off edge", k, 3);
        chk("R12 fault on shutdown", int'(fault), 1);
        pwm = 1'b0;
        wait_neg(15);
        chk("R7 phase ignored, pair low", int'({hs, ls}), 0);
        pwm = 1'b1;
        wait_neg(15);
        chk("R7 phase ignored again", int'({hs, ls}), 0);
        shdn_n = 1'b1;
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (k == 2) chk("R12 fault held at edge 1", int'(fault), 1);
            if (k == 3) chk("R12 fault cleared at edge 2", int'(fault), 0);
            if (hs) break;
        end
        chk("R7 release turn-on edge", k, 10 + 2);

        // ---------------- R8 logic-supply lockout ----------------
        lv_fall = 1'b1;
        k = 0;
        while (k < 50) begin
            @(negedge clk);
            k++;
            if (!hs) break;
        end
        chk("R8 lockout turn-off edge", k, 2);
        chk("R12 fault on lockout", int'(fault), 1);
        lv_fall = 1'b0;
        wait_neg(20);
        chk("R8 band keeps lockout", int'({hs, ls}), 0);
        lv_rise = 1'b1;
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (hs) break;
        end
        chk("R10 lockout release turn-on", k, 10 + 1);
        lv_rise = 1'b0;

        // ---------------- R9 high-side lockout ----------------
        hv_fall = 1'b1;
        k = 0;
        while (k < 50) begin
            @(negedge clk);
            k++;
            if (!hs) break;
        end
        chk("R9 hs removed at edge 1", k, 2);
        chk("R9 ls not forced on", int'(ls), 0);
        chk("R12 fault on floating lockout", int'(fault), 1);
        pwm = 1'b0;
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (ls) break;
        end
        chk("R9 low side hands over normally", k, 10 + 3);
        hv_fall = 1'b0;
        wait_neg(10);
        chk("R9 ls stays on, hs off", int'({hs, ls}), 1);
        chk("R12 fault held in band", int'(fault), 1);
        hv_rise = 1'b1;
        wait_neg(3);
        chk("R9 release leaves ls on", int'({hs, ls}), 1);
        chk("R12 fault cleared", int'(fault), 0);
        hv_rise = 1'b0;
        switch_to(1'b1, 0, "R9 resume");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule